// File: doc/BRIEF.md
# Byte-Wide Four-Mode Instruction Core

This block is a small processor core for an 8-bit machine. Registers, data and addresses are all one byte wide. Each instruction is two bytes long and sits at two consecutive memory addresses. The core fetches both bytes over a single byte-wide synchronous memory port and splits the 16-bit word into four fields: an opcode, an addressing mode, a register number and an operand byte. It then resolves the operand through one of four addressing modes and executes a load, a store, a jump or an ALU operation.

The core holds eight byte registers, a program counter, an instruction register and sign, zero and carry flags. Memory is a plain synchronous RAM: a read issued in one cycle returns its data in the next. The core stops on a STOP instruction and raises `halted`. An instruction that has no meaning in its addressing mode does nothing, and it sets a sticky status output that only reset clears.

Top module: `octet_core`

## Requirements
- R1: Reset clears the program counter, all eight registers and the flags, and holds `halted` and `illegal_seen` low. In the first cycle after reset the core reads address 0.
- R2: An instruction is fetched as two reads. The first, at the program counter, supplies bits 7..0. The second, at the program counter plus 1, supplies bits 15..8. The word splits as opcode [15:13], mode [12:11], register [10:8] and operand byte [7:0]. A retired instruction that does not jump advances the program counter by 2.
- R3: Register codes 0 to 7 select eight independent byte registers, named AL, AH, BL, BH, CL, CH, DL and DH in that order.
- R4: Mode 00 uses the operand byte as the address. Mode 01 reads memory at the operand byte and uses the returned byte as the address. Mode 10 selects the register whose number is in operand bits 2..0. Mode 11 uses the operand byte itself as the value.
- R5: Opcode 001 (load) copies the operand value into the selected register and leaves the flags unchanged.
- R6: Opcode 010 (store) writes the selected register to the resolved memory address in modes 00 and 01. In mode 10 it writes the register into the register named by operand bits 2..0.
- R7: Opcodes 011, 100 and 101 compute register = register op operand for add, subtract and bitwise AND. Sign is result bit 7. Zero is set when the result is 0. Carry is the carry out for add, the borrow for subtract, and 0 for AND.
- R8: Opcode 110 jumps to the resolved address when the zero flag is 1 and otherwise falls through. Opcode 111 always jumps. Jumps use mode 00 or mode 01.
- R9: A store in mode 11, or a jump in mode 10 or 11, writes nothing and does not jump. The program counter advances by 2, and `illegal_seen` goes high and stays high until reset.
- R10: Opcode 000 stops the core. `halted` then stays high and the core makes no further memory reads or writes.
- R11: The core never asserts read and write in the same cycle. Read data is taken from the port in the cycle after the read was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data from the previous cycle's read |
| halted | output | 1 | High once a STOP has executed |
| illegal_seen | output | 1 | Sticky flag for an illegal store or jump mode |

## Verification
The assertions assume that the memory behaves as a single-cycle synchronous RAM: `mem_rdata` in a cycle reflects the read issued in the cycle before, and reset lasts at least one clock. The bench keeps to this assumption by modelling memory as one clocked array. It loads each program image into that array while reset is held, so that loading never competes with a core write. Every program ends in STOP, and every jump target and pointer lies inside the loaded image, so that any fetch outside the image decodes as STOP.

// File: rtl/octet_pkg.sv
package octet_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_REGS  = 8;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int INSN_W    = 2 * BYTE_W;
    localparam int OPC_W     = 3;
    localparam int MODE_W    = 2;
    localparam int OPC_LSB   = INSN_W - OPC_W;
    localparam int MODE_LSB  = OPC_LSB - MODE_W;
    localparam int RN_LSB    = MODE_LSB - REG_IDX_W;
    localparam int INSN_BYTES = INSN_W / BYTE_W;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT = 3'b000,
        OP_LD   = 3'b001,
        OP_ST   = 3'b010,
        OP_ADD  = 3'b011,
        OP_SUB  = 3'b100,
        OP_AND  = 3'b101,
        OP_JZ   = 3'b110,
        OP_JMP  = 3'b111
    } opcode_e;

    typedef enum logic [MODE_W-1:0] {
        AM_DIR = 2'b00,
        AM_IND = 2'b01,
        AM_REG = 2'b10,
        AM_IMM = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_DECODE,
        ST_INDIR,
        ST_EADDR,
        ST_OPND,
        ST_HALT
    } core_state_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        core_state_e                          state;
        logic [BYTE_W-1:0]                    pc;
        logic [INSN_W-1:0]                    ir;
        logic [BYTE_W-1:0]                    ea;
        logic [NUM_REGS-1:0][BYTE_W-1:0]      gpr;
        alu_flags_t                           fl;
        logic                                 bad;
    } core_regs_t;

endpackage

// File: rtl/octet_decode.sv
module octet_decode
    import octet_pkg::*;
(
    input  logic [INSN_W-1:0]    insn,
    output opcode_e              opc,
    output amode_e               mode,
    output logic [REG_IDX_W-1:0] rn,
    output logic [BYTE_W-1:0]    fld,
    output logic [REG_IDX_W-1:0] rsel,
    output logic                 illegal
);

    logic is_jump;

    always_comb begin
        opc     = opcode_e'(insn[OPC_LSB +: OPC_W]);
        mode    = amode_e'(insn[MODE_LSB +: MODE_W]);
        rn      = insn[RN_LSB +: REG_IDX_W];
        fld     = insn[BYTE_W-1:0];
        rsel    = fld[REG_IDX_W-1:0];
        is_jump = (opc == OP_JZ) || (opc == OP_JMP);
        // immediate has no address to store into; register/immediate give no jump target
        illegal = ((opc == OP_ST) && (mode == AM_IMM)) ||
                  (is_jump && ((mode == AM_REG) || (mode == AM_IMM)));
    end

endmodule

// File: rtl/octet_alu.sv
module octet_alu
    import octet_pkg::*;
(
    input  opcode_e           op,
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    output logic [BYTE_W-1:0] res,
    output alu_flags_t        fl
);

    logic [BYTE_W:0] wide;

    always_comb begin
        unique case (op)
            OP_ADD:  wide = {1'b0, a} + {1'b0, b};
            OP_SUB:  wide = {1'b0, a} - {1'b0, b};
            default: wide = {1'b0, a & b};
        endcase
        res  = wide[BYTE_W-1:0];
        fl.s = res[BYTE_W-1];
        fl.z = (res == '0);
        fl.c = wide[BYTE_W];
    end

endmodule

// File: rtl/octet_core.sv
module octet_core
    import octet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [BYTE_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              halted,
    output logic              illegal_seen
);

    localparam logic [BYTE_W-1:0] PC_STEP = BYTE_W'(INSN_BYTES);
    localparam logic [BYTE_W-1:0] HI_OFS  = BYTE_W'(1);

    core_regs_t core_q, core_d;

    logic [INSN_W-1:0]    dec_in;
    opcode_e              d_opc;
    amode_e               d_mode;
    logic [REG_IDX_W-1:0] d_rn;
    logic [BYTE_W-1:0]    d_fld;
    logic [REG_IDX_W-1:0] d_rsel;
    logic                 d_illegal;

    logic [BYTE_W-1:0]    opnd;
    logic [BYTE_W-1:0]    alu_res;
    alu_flags_t           alu_fl;

    logic                 exec, retire;

    // In DECODE the high byte is still on the read port; decode it in place
    assign dec_in = (core_q.state == ST_DECODE) ?
                    {mem_rdata, core_q.ir[BYTE_W-1:0]} : core_q.ir;

    octet_decode u_dec (
        .insn    (dec_in),
        .opc     (d_opc),
        .mode    (d_mode),
        .rn      (d_rn),
        .fld     (d_fld),
        .rsel    (d_rsel),
        .illegal (d_illegal)
    );

    always_comb begin
        if (core_q.state == ST_OPND)
            opnd = mem_rdata;
        else if (d_mode == AM_REG)
            opnd = core_q.gpr[d_rsel];
        else
            opnd = d_fld;
    end

    octet_alu u_alu (
        .op  (d_opc),
        .a   (core_q.gpr[d_rn]),
        .b   (opnd),
        .res (alu_res),
        .fl  (alu_fl)
    );

    always_comb begin
        core_d    = core_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = core_q.pc;
        mem_wdata = core_q.gpr[d_rn];
        exec      = 1'b0;
        retire    = 1'b0;

        unique case (core_q.state)
            ST_FETCH_LO: begin
                mem_rd       = 1'b1;
                mem_addr     = core_q.pc;
                core_d.state = ST_FETCH_HI;
            end
            ST_FETCH_HI: begin
                core_d.ir[BYTE_W-1:0] = mem_rdata;
                mem_rd       = 1'b1;
                mem_addr     = core_q.pc + HI_OFS;
                core_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                core_d.ir[INSN_W-1:BYTE_W] = mem_rdata;
                if (d_opc == OP_HALT) begin
                    core_d.state = ST_HALT;
                end else if (d_illegal) begin
                    core_d.bad = 1'b1;
                    retire     = 1'b1;
                end else begin
                    unique case (d_mode)
                        AM_DIR: begin
                            core_d.ea    = d_fld;
                            core_d.state = ST_EADDR;
                        end
                        AM_IND: begin
                            mem_rd       = 1'b1;
                            mem_addr     = d_fld;
                            core_d.state = ST_INDIR;
                        end
                        default: begin
                            if (d_opc == OP_ST) begin
                                core_d.gpr[d_rsel] = core_q.gpr[d_rn];
                                retire = 1'b1;
                            end else begin
                                exec = 1'b1;
                            end
                        end
                    endcase
                end
            end
            ST_INDIR: begin
                core_d.ea    = mem_rdata;
                core_d.state = ST_EADDR;
            end
            ST_EADDR: begin
                unique case (d_opc)
                    OP_ST: begin
                        mem_wr   = 1'b1;
                        mem_addr = core_q.ea;
                        retire   = 1'b1;
                    end
                    OP_JZ: begin
                        if (core_q.fl.z) begin
                            core_d.pc    = core_q.ea;
                            core_d.state = ST_FETCH_LO;
                        end else begin
                            retire = 1'b1;
                        end
                    end
                    OP_JMP: begin
                        core_d.pc    = core_q.ea;
                        core_d.state = ST_FETCH_LO;
                    end
                    default: begin
                        mem_rd       = 1'b1;
                        mem_addr     = core_q.ea;
                        core_d.state = ST_OPND;
                    end
                endcase
            end
            ST_OPND: begin
                exec = 1'b1;
            end
            ST_HALT: begin
                core_d.state = ST_HALT;
            end
            default: begin
                core_d.state = ST_HALT;
            end
        endcase

        if (exec) begin
            if (d_opc == OP_LD) begin
                core_d.gpr[d_rn] = opnd;
            end else begin
                core_d.gpr[d_rn] = alu_res;
                core_d.fl        = alu_fl;
            end
            retire = 1'b1;
        end

        if (retire) begin
            core_d.pc    = core_q.pc + PC_STEP;
            core_d.state = ST_FETCH_LO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.state <= ST_FETCH_LO;
        end else begin
            core_q <= core_d;
        end
    end

    assign halted       = (core_q.state == ST_HALT);
    assign illegal_seen = core_q.bad;

endmodule

// File: rtl/octet_core_chk.sv
module octet_core_chk
    import octet_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [BYTE_W-1:0] mem_addr,
    input logic              halted,
    input logic              illegal_seen,
    input core_state_e       state
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_rd && mem_addr == '0 && !halted && !illegal_seen)); // R1

    AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_LO) |=>
            (state == ST_FETCH_HI && mem_rd && mem_addr == $past(mem_addr) + BYTE_W'(1))); // R2

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R10

    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr)); // R10

    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_seen |=> illegal_seen); // R9

    AST_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (state == ST_EADDR)); // R6

endmodule

bind octet_core octet_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_addr     (mem_addr),
    .halted       (halted),
    .illegal_seen (illegal_seen),
    .state        (core_q.state)
);

// File: tb/octet_core_tb.sv
module octet_core_tb;

    localparam logic [2:0] K_STOP = 3'd0, K_LD = 3'd1, K_ST = 3'd2, K_ADD = 3'd3,
                           K_SUB = 3'd4, K_AND = 3'd5, K_JZ = 3'd6, K_JMP = 3'd7;
    localparam logic [1:0] M_DIR = 2'd0, M_IND = 2'd1, M_REG = 2'd2, M_IMM = 2'd3;
    localparam logic [2:0] AL = 3'd0, AH = 3'd1, BL = 3'd2, BH = 3'd3,
                           CL = 3'd4, CH = 3'd5, DL = 3'd6, DH = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_rd, mem_wr, halted, illegal_seen;

    always #5 clk = ~clk;

    octet_core u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_addr     (mem_addr),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .halted       (halted),
        .illegal_seen (illegal_seen)
    );

    logic [7:0] mem [256];
    logic [7:0] img [256];
    logic       img_load = 1'b0;

    always @(posedge clk) begin
        if (img_load) begin
            for (int i = 0; i < 256; i++) mem[i] <= img[i];
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    int n_chk = 0, n_bad = 0, cycles = 0, collide = 0;

    always @(negedge clk) begin
        cycles++;
        if (mem_rd && mem_wr) collide++;
    end

    initial begin
        wait (cycles >= 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [2:0] op, input logic [1:0] md,
                                        input logic [2:0] rn, input logic [7:0] f);
        return {op, md, rn, f};
    endfunction

    task automatic put(input int a, input logic [15:0] w);
        img[a % 256]       = w[7:0];
        img[(a + 1) % 256] = w[15:8];
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
    endtask

    task automatic boot();
        @(negedge clk);
        rst_n    = 1'b0;
        img_load = 1'b1;
        @(negedge clk);
        @(negedge clk);
        img_load = 1'b0;
        rst_n    = 1'b1;
    endtask

    task automatic run_to_halt(input string req);
        int n = 0;
        while (!halted && n < 600) begin
            @(negedge clk);
            n++;
        end
        chk(halted == 1'b1, req, int'(halted), 1);
    endtask

    function automatic logic [7:0] alu_ref(input int op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            3:       return a + b;
            4:       return a - b;
            default: return a & b;
        endcase
    endfunction

    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h0F};

    initial begin
        // ---- R1/R2/R10: reset state, fetch order, halt idle ----
        clear_img();
        img[8'hC0] = 8'h5A;
        img[8'hC1] = 8'hA5;
        put(0, enc(K_ST, M_DIR, DH, 8'hC0));
        put(2, enc(K_ST, M_DIR, AL, 8'hC1));
        boot();
        chk(mem_rd && mem_addr == 8'h00, "R1 first read at 0", int'(mem_addr), 0);
        chk(!halted && !illegal_seen, "R1 status low", int'({halted, illegal_seen}), 0);
        @(negedge clk);
        chk(mem_rd && mem_addr == 8'h01, "R2 high byte read", int'(mem_addr), 1);
        @(negedge clk);
        @(negedge clk);
        chk(mem_wr && mem_addr == 8'hC0, "R2 decoded store", int'(mem_addr), 8'hC0);
        @(negedge clk);
        chk(mem_rd && mem_addr == 8'h02, "R2 pc step 2", int'(mem_addr), 2);
        run_to_halt("R10 stop");
        chk(mem[8'hC0] == 8'h00, "R1 DH cleared", int'(mem[8'hC0]), 0);
        chk(mem[8'hC1] == 8'h00, "R1 AL cleared", int'(mem[8'hC1]), 0);
        begin
            int acc = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (mem_rd || mem_wr) acc++;
            end
            chk(acc == 0 && halted, "R10 idle after stop", acc, 0);
        end

        // ---- R3: all eight registers independent ----
        clear_img();
        for (int i = 0; i < 8; i++) begin
            put(2 * i, enc(K_LD, M_IMM, 3'(i), 8'(8'h10 + i * 8'h11)));
            put(16 + 2 * i, enc(K_ST, M_DIR, 3'(i), 8'(8'hB0 + i)));
        end
        boot();
        run_to_halt("R3 stop");
        for (int i = 0; i < 8; i++)
            chk(mem[8'hB0 + i] == 8'(8'h10 + i * 8'h11), "R3 register",
                int'(mem[8'hB0 + i]), int'(8'(8'h10 + i * 8'h11)));

        // ---- R5/R6: load keeps flags, register store, indirect store ----
        clear_img();
        img[8'hD0] = 8'hD8;
        put(0,  enc(K_LD,  M_IMM, AL, 8'h05));
        put(2,  enc(K_SUB, M_IMM, AL, 8'h05));
        put(4,  enc(K_LD,  M_IMM, BH, 8'h77));
        put(6,  enc(K_ST,  M_REG, BH, 8'h06));
        put(8,  enc(K_LD,  M_REG, CH, 8'h06));
        put(10, enc(K_ST,  M_DIR, CH, 8'hC2));
        put(12, enc(K_JZ,  M_DIR, AL, 8'h12));
        put(14, enc(K_LD,  M_IMM, CL, 8'h01));
        put(16, enc(K_JMP, M_DIR, AL, 8'h14));
        put(18, enc(K_LD,  M_IMM, CL, 8'h02));
        put(20, enc(K_ST,  M_DIR, CL, 8'hC3));
        put(22, enc(K_ST,  M_IND, CH, 8'hD0));
        boot();
        run_to_halt("R5 stop");
        chk(mem[8'hC2] == 8'h77, "R6 register-mode store", int'(mem[8'hC2]), 8'h77);
        chk(mem[8'hC3] == 8'h02, "R5 load keeps zero flag", int'(mem[8'hC3]), 2);
        chk(mem[8'hD8] == 8'h77, "R6 indirect store", int'(mem[8'hD8]), 8'h77);

        // ---- R8: not-taken branch, indirect jump, indirect taken branch ----
        clear_img();
        img[8'hD4] = 8'h30;
        img[8'hD5] = 8'h40;
        put(0,    enc(K_LD,  M_IMM, AL, 8'h01));
        put(2,    enc(K_ADD, M_IMM, AL, 8'h01));
        put(4,    enc(K_JZ,  M_DIR, AL, 8'h20));
        put(6,    enc(K_JMP, M_IND, AL, 8'hD4));
        put(8,    enc(K_LD,  M_IMM, DL, 8'hE2));
        put(10,   enc(K_ST,  M_DIR, DL, 8'hC4));
        put(8'h20, enc(K_LD, M_IMM, DL, 8'hE1));
        put(8'h22, enc(K_ST, M_DIR, DL, 8'hC4));
        put(8'h30, enc(K_SUB, M_IMM, AL, 8'h02));
        put(8'h32, enc(K_JZ,  M_IND, AL, 8'hD5));
        put(8'h34, enc(K_LD,  M_IMM, DL, 8'h34));
        put(8'h36, enc(K_ST,  M_DIR, DL, 8'hC4));
        put(8'h40, enc(K_LD,  M_IMM, DL, 8'h4D));
        put(8'h42, enc(K_ST,  M_DIR, DL, 8'hC4));
        boot();
        run_to_halt("R8 stop");
        chk(mem[8'hC4] == 8'h4D, "R8 jump chain", int'(mem[8'hC4]), 8'h4D);

        // ---- R9: illegal modes ----
        clear_img();
        put(0,    enc(K_LD,  M_IMM, AL, 8'h99));
        put(2,    enc(K_AND, M_IMM, BL, 8'h00));
        put(4,    enc(K_ST,  M_IMM, AL, 8'hC5));
        put(6,    enc(K_JMP, M_REG, AL, 8'h10));
        put(8,    enc(K_JZ,  M_IMM, AL, 8'h10));
        put(10,   enc(K_ST,  M_DIR, AL, 8'hC6));
        put(8'h10, enc(K_ST, M_DIR, AL, 8'hC7));
        boot();
        chk(!illegal_seen, "R9 clear before", int'(illegal_seen), 0);
        run_to_halt("R9 stop");
        chk(mem[8'hC5] == 8'h00, "R9 no immediate store", int'(mem[8'hC5]), 0);
        chk(mem[8'hC6] == 8'h99, "R9 falls through", int'(mem[8'hC6]), 8'h99);
        chk(mem[8'hC7] == 8'h00, "R9 no jump taken", int'(mem[8'hC7]), 0);
        chk(illegal_seen, "R9 sticky flag", int'(illegal_seen), 1);
        boot();
        chk(!illegal_seen, "R1 reset clears sticky flag", int'(illegal_seen), 0);

        // ---- R4/R7/R8: sweep ALU ops x modes x operand pairs ----
        for (int op = 3; op <= 5; op++)
            for (int md = 0; md < 4; md++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++) begin
                        logic [7:0] a, b, f, e;
                        a = vals[i];
                        b = vals[j];
                        clear_img();
                        img[8'h80] = b;
                        img[8'h90] = 8'h80;
                        case (md)
                            0:       f = 8'h80;
                            1:       f = 8'h90;
                            2:       f = {5'd0, BL};
                            default: f = b;
                        endcase
                        put(0,  enc(K_LD, M_IMM, BL, b));
                        put(2,  enc(K_LD, M_IMM, AL, a));
                        put(4,  enc(3'(op), 2'(md), AL, f));
                        put(6,  enc(K_ST, M_DIR, AL, 8'hA0));
                        put(8,  enc(K_JZ, M_DIR, AL, 8'h0E));
                        put(10, enc(K_LD, M_IMM, CL, 8'h11));
                        put(12, enc(K_JMP, M_DIR, AL, 8'h10));
                        put(14, enc(K_LD, M_IMM, CL, 8'h22));
                        put(16, enc(K_ST, M_DIR, CL, 8'hA1));
                        boot();
                        run_to_halt("R10 sweep stop");
                        e = alu_ref(op, a, b);
                        chk(mem[8'hA0] == e, "R7 R4 result", int'(mem[8'hA0]), int'(e));
                        chk(mem[8'hA1] == ((e == 8'h00) ? 8'h22 : 8'h11), "R8 zero branch",
                            int'(mem[8'hA1]), (e == 8'h00) ? 8'h22 : 8'h11);
                    end

        chk(collide == 0, "R11 read/write exclusive", collide, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule